// File: doc/BRIEF.md
# Keypad Matrix Scanner with Event Queue

This block scans an 8x8 key matrix and up to eight special-function keys, turns every debounced press or release into a one-byte event code, and queues the codes for a host. One column drive line at a time is pulled low while the eight row sense lines are sampled. A special-function key ties its row straight to ground, so one more sample is taken with no column driven. After a detected change, the block waits a programmable debounce time and rescans. It accepts the new key state only if the confirming scan sees the same pattern.

Time is counted in pulses of `tick_i`. A periodic scan starts every `SCAN_TICKS` ticks, and the debounce wait is the register value times `DEB_TICKS` ticks. A small configuration port sets the debounce register and can request an immediate rescan. The host drains the queue through a pop read or a repeat read. Pulses for key overrun and queue overrun are sent to a separate interrupt block.

Top module: `kpd_scan_top`

## Requirements
- R1: Outside a scan, `col_o` is all ones. During scan phase p (0..7), only bit p of `col_o` is low. Phase 8 samples the special-function keys with all columns high.
- R2: While idle, a scan starts every `SCAN_TICKS` ticks. A scan takes 9 clocks plus 1 evaluation clock. After a change is seen, the confirming scan starts `max(deb,1)*DEB_TICKS` ticks after the evaluation. With a tick on every clock, two successive scan starts are then `10 + max(deb,1)*DEB_TICKS` clocks apart.
- R3: The debounce register is written with `cfg_we_i=1` and `cfg_addr_i=0`. It resets to `DEB_DEFAULT` (3), and a written value of 0 acts as 1.
- R4: An event code is {bit7 = 1 for press and 0 for release, bits 6:4 = row index, bits 3:0 = column index + 1}. A special-function key on row r uses code r*16 + 9.
- R5: While a special-function key is held, every other key on its row is masked and produces no event.
- R6: Events from one accepted change are queued in ascending row order, and by column within a row, with the special-function key after the columns. Changes accepted at different times are queued in the order they were accepted.
- R7: The queue holds up to `FIFO_DEPTH` (14) events. A pop read (`rd_pop_i`) places the head on `rd_data_o` one clock later and removes it. A read of the empty queue returns 0x00.
- R8: A repeat read (`rd_peek_i`) places the head on `rd_data_o` one clock later and leaves the queue unchanged.
- R9: `key_ovr_o` pulses for one clock when an accepted key state has more than two keys pressed. The events are still queued.
- R10: An event that arrives while the queue is full is dropped, and `fifo_ovr_o` pulses. The stored events are kept.
- R11: `evt_stb_o` pulses once for each event written into the queue.
- R12: A write with `cfg_we_i=1` and `cfg_addr_i=1` starts a scan. When the scanner is idle, column 0 is driven on the next clock. No scan starts while idle without ticks or a request.
- R13: After reset, `col_o` is 0xFF, `rd_data_o` is 0x00, and every pulse output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Time-base enable pulse |
| row_i | input | 8 | Row sense lines, low when a key connects the row |
| col_o | output | 8 | Column drive lines, low for the driven column |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 1 | 0 selects the debounce register, 1 requests a scan |
| cfg_wdata_i | input | 8 | Configuration write data |
| rd_pop_i | input | 1 | Read the queue head and remove it |
| rd_peek_i | input | 1 | Read the queue head and keep it |
| rd_data_o | output | 8 | Read result, 0x00 when the queue is empty |
| evt_stb_o | output | 1 | Pulse for each queued event |
| key_ovr_o | output | 1 | Pulse when more than two keys are held |
| fifo_ovr_o | output | 1 | Pulse when an event is lost to a full queue |

## Verification
The assertions assume that `row_i` settles within the clock in which a column is driven. They also assume that configuration writes and read requests last one clock, and that scan requests arrive only while the scanner is idle. The bench models the matrix as a combinational function of `col_o`, so every column sample sees the current switch state. It holds each key change far longer than a debounce window and pulses every strobe for a single clock. It stops `tick_i` only after all activity has settled, so a scan request is issued only to an idle scanner.

// File: rtl/kpd_pkg.sv
package kpd_pkg;
  localparam int ROWS = 8;
  localparam int COLS = 8;
  localparam int NPH  = COLS + 1;    // column phases plus the special-key phase
  localparam int NK   = ROWS * NPH;

  typedef enum logic [2:0] {ST_IDLE, ST_SCAN, ST_EVAL, ST_DEB, ST_EMIT} seq_st_e;

  function automatic logic [7:0] ev_code(logic press, logic [2:0] r, logic [3:0] c);
    return {press, r, c + 4'd1};
  endfunction
endpackage

// File: rtl/kpd_seq.sv
module kpd_seq
  import kpd_pkg::*;
#(
  parameter int SCAN_TICKS  = 4,
  parameter int DEB_TICKS   = 3,
  parameter int DEB_DEFAULT = 3,
  parameter int CNT_W       = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic [7:0]    row_i,
  output logic [7:0]    col_o,
  input  logic          cfg_we_i,
  input  logic          cfg_addr_i,
  input  logic [7:0]    cfg_wdata_i,
  input  logic          emit_busy_i,
  output logic          ld_o,
  output logic [NK-1:0] diff_o,
  output logic [NK-1:0] state_o,
  output logic          key_ovr_o
);
  seq_st_e          st_q;
  logic [3:0]       ph_q;
  logic [CNT_W-1:0] cnt_q;
  logic [7:0]       deb_q;
  logic             req_q, conf_q;
  logic [NK-1:0]    raw_q, cand_q, stable_q, scan_v;
  logic [CNT_W-1:0] deb_lim;

  wire req_w = cfg_we_i && cfg_addr_i;

  assign deb_lim = CNT_W'(deb_q) * CNT_W'(DEB_TICKS);
  assign state_o = stable_q;

  always_comb begin
    col_o = '1;
    if (st_q == ST_SCAN && ph_q < 4'(COLS)) col_o = ~(8'b1 << ph_q);
  end

  // a held special key forces its whole row to read as released
  always_comb begin
    for (int r = 0; r < ROWS; r++) begin
      for (int c = 0; c < COLS; c++)
        scan_v[r*NPH+c] = raw_q[r*NPH+c] & ~raw_q[r*NPH+COLS];
      scan_v[r*NPH+COLS] = raw_q[r*NPH+COLS];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      ph_q      <= '0;
      cnt_q     <= '0;
      deb_q     <= 8'(DEB_DEFAULT);
      req_q     <= 1'b0;
      conf_q    <= 1'b0;
      raw_q     <= '0;
      cand_q    <= '0;
      stable_q  <= '0;
      diff_o    <= '0;
      ld_o      <= 1'b0;
      key_ovr_o <= 1'b0;
    end else begin
      ld_o      <= 1'b0;
      key_ovr_o <= 1'b0;
      if (cfg_we_i && !cfg_addr_i) deb_q <= (cfg_wdata_i == 8'd0) ? 8'd1 : cfg_wdata_i;
      if (req_w) req_q <= 1'b1;
      unique case (st_q)
        ST_IDLE: begin
          if (req_w || req_q) begin
            st_q  <= ST_SCAN;
            ph_q  <= '0;
            cnt_q <= '0;
            req_q <= 1'b0;
          end else if (tick_i) begin
            if (cnt_q == CNT_W'(SCAN_TICKS - 1)) begin
              st_q  <= ST_SCAN;
              ph_q  <= '0;
              cnt_q <= '0;
            end else cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_SCAN: begin
          for (int r = 0; r < ROWS; r++) raw_q[r*NPH + int'(ph_q)] <= ~row_i[r];
          if (ph_q == 4'(COLS)) st_q <= ST_EVAL;
          else ph_q <= ph_q + 1'b1;
        end
        ST_EVAL: begin
          cnt_q <= '0;
          if (scan_v == stable_q) begin
            conf_q <= 1'b0;
            st_q   <= ST_IDLE;
          end else if (conf_q && scan_v == cand_q) begin
            conf_q    <= 1'b0;
            stable_q  <= scan_v;
            diff_o    <= scan_v ^ stable_q;
            ld_o      <= 1'b1;
            key_ovr_o <= ($countones(scan_v) > 2);
            st_q      <= ST_EMIT;
          end else begin
            cand_q <= scan_v;
            conf_q <= 1'b1;
            st_q   <= ST_DEB;
          end
        end
        ST_DEB: begin
          if (tick_i) begin
            if (cnt_q == deb_lim - 1'b1) begin
              st_q  <= ST_SCAN;
              ph_q  <= '0;
              cnt_q <= '0;
            end else cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_EMIT: begin
          if (!emit_busy_i && !ld_o) begin
            st_q  <= ST_IDLE;
            cnt_q <= '0;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  a_r1_one_col: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(~col_o) <= 1);
  a_r12_req_starts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE && req_w) |=> (col_o == 8'hFE));
  a_r3_deb_nonzero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    deb_q != 8'd0);
  a_r9_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    key_ovr_o |=> !key_ovr_o);
endmodule

// File: rtl/kpd_emit.sv
module kpd_emit
  import kpd_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ld_i,
  input  logic [NK-1:0] diff_i,
  input  logic [NK-1:0] state_i,
  output logic          valid_o,
  output logic [7:0]    code_o,
  output logic          busy_o
);
  logic [NK-1:0] pend_q, clr;
  logic [2:0]    sel_r;
  logic [3:0]    sel_c;

  // descending walk so the lowest pending index wins
  always_comb begin
    valid_o = 1'b0;
    sel_r   = '0;
    sel_c   = '0;
    clr     = '0;
    for (int r = ROWS - 1; r >= 0; r--) begin
      for (int c = NPH - 1; c >= 0; c--) begin
        if (pend_q[r*NPH+c]) begin
          valid_o = 1'b1;
          sel_r   = 3'(r);
          sel_c   = 4'(c);
          clr     = '0;
          clr[r*NPH+c] = 1'b1;
        end
      end
    end
    code_o = ev_code(|(state_i & clr), sel_r, sel_c);
  end

  assign busy_o = |pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else if (ld_i) pend_q <= diff_i;
    else pend_q <= pend_q & ~clr;
  end

  a_r6_one_per_clk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !ld_i) |=> ($countones(pend_q) == $past($countones(pend_q)) - 1));
endmodule

// File: rtl/kpd_fifo.sv
module kpd_fifo #(
  parameter int DEPTH = 14
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       push_i,
  input  logic [7:0] data_i,
  input  logic       pop_i,
  input  logic       peek_i,
  output logic [7:0] rd_data_o,
  output logic       stb_o,
  output logic       ovr_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [7:0]    mem_q [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [CW-1:0] cnt_q;
  logic          full, empty, push_ok, pop_ok;

  assign full    = (cnt_q == CW'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign push_ok = push_i && !full;
  assign pop_ok  = pop_i && !empty;

  always_ff @(posedge clk_i) begin
    if (push_ok) mem_q[wp_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q      <= '0;
      rp_q      <= '0;
      cnt_q     <= '0;
      rd_data_o <= '0;
      stb_o     <= 1'b0;
      ovr_o     <= 1'b0;
    end else begin
      stb_o <= push_ok;
      ovr_o <= push_i && full;
      if (push_ok) wp_q <= (wp_q == AW'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
      if (pop_ok)  rp_q <= (rp_q == AW'(DEPTH - 1)) ? '0 : rp_q + 1'b1;
      if (pop_i || peek_i) rd_data_o <= empty ? 8'h00 : mem_q[rp_q];
      cnt_q <= cnt_q + CW'(push_ok) - CW'(pop_ok);
    end
  end

  a_r7_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(DEPTH));
  a_r10_keep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && full && !pop_i) |=> (cnt_q == CW'(DEPTH)) && $stable(rp_q));
  a_r8_peek_still: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (peek_i && !pop_i && !push_i) |=> $stable(cnt_q) && $stable(rp_q));
  a_r11_stb: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !full) |=> stb_o);
endmodule

// File: rtl/kpd_scan_top.sv
module kpd_scan_top
  import kpd_pkg::*;
#(
  parameter int SCAN_TICKS  = 4,
  parameter int DEB_TICKS   = 3,
  parameter int DEB_DEFAULT = 3,
  parameter int FIFO_DEPTH  = 14,
  parameter int CNT_W       = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic [7:0] row_i,
  output logic [7:0] col_o,
  input  logic       cfg_we_i,
  input  logic       cfg_addr_i,
  input  logic [7:0] cfg_wdata_i,
  input  logic       rd_pop_i,
  input  logic       rd_peek_i,
  output logic [7:0] rd_data_o,
  output logic       evt_stb_o,
  output logic       key_ovr_o,
  output logic       fifo_ovr_o
);
  logic          ld, busy, ev_valid;
  logic [NK-1:0] diff, state;
  logic [7:0]    ev_code_w;

  kpd_seq #(
    .SCAN_TICKS (SCAN_TICKS),
    .DEB_TICKS  (DEB_TICKS),
    .DEB_DEFAULT(DEB_DEFAULT),
    .CNT_W      (CNT_W)
  ) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick_i),
    .row_i      (row_i),
    .col_o      (col_o),
    .cfg_we_i   (cfg_we_i),
    .cfg_addr_i (cfg_addr_i),
    .cfg_wdata_i(cfg_wdata_i),
    .emit_busy_i(busy),
    .ld_o       (ld),
    .diff_o     (diff),
    .state_o    (state),
    .key_ovr_o  (key_ovr_o)
  );

  kpd_emit u_emit (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ld_i   (ld),
    .diff_i (diff),
    .state_i(state),
    .valid_o(ev_valid),
    .code_o (ev_code_w),
    .busy_o (busy)
  );

  kpd_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .push_i   (ev_valid),
    .data_i   (ev_code_w),
    .pop_i    (rd_pop_i),
    .peek_i   (rd_peek_i),
    .rd_data_o(rd_data_o),
    .stb_o    (evt_stb_o),
    .ovr_o    (fifo_ovr_o)
  );
endmodule

// File: tb/sim_kpd_scan_top.sv
module sim_kpd_scan_top;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic tick_i = 1'b1;
  logic [7:0] row_i, col_o;
  logic cfg_we_i = 1'b0, cfg_addr_i = 1'b0;
  logic [7:0] cfg_wdata_i = '0;
  logic rd_pop_i = 1'b0, rd_peek_i = 1'b0;
  logic [7:0] rd_data_o;
  logic evt_stb_o, key_ovr_o, fifo_ovr_o;

  logic [7:0][7:0] keys = '0;
  logic [7:0]      sf = '0;
  int n_chk = 0, n_bad = 0, cyc = 0;
  int stb_cnt = 0, kovr_cnt = 0, fovr_cnt = 0;
  bit done = 0;

  always #4 clk = ~clk;   // 125 MHz

  kpd_scan_top u0 (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick_i), .row_i(row_i), .col_o(col_o),
    .cfg_we_i(cfg_we_i), .cfg_addr_i(cfg_addr_i), .cfg_wdata_i(cfg_wdata_i),
    .rd_pop_i(rd_pop_i), .rd_peek_i(rd_peek_i), .rd_data_o(rd_data_o),
    .evt_stb_o(evt_stb_o), .key_ovr_o(key_ovr_o), .fifo_ovr_o(fifo_ovr_o)
  );

  // switch matrix: a row goes low when a closed key meets a driven column
  always_comb
    for (int r = 0; r < 8; r++) row_i[r] = ~(sf[r] | (|(keys[r] & ~col_o)));

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst_ni) begin
      if (evt_stb_o)  stb_cnt  <= stb_cnt + 1;
      if (key_ovr_o)  kovr_cnt <= kovr_cnt + 1;
      if (fifo_ovr_o) fovr_cnt <= fovr_cnt + 1;
    end
  end

  // {press, sf, row[2:0], col[2:0], expected code}
  localparam logic [15:0] VEC [8] = '{
    16'h8081, 16'h0001, 16'hBFF8, 16'h3F78,
    16'h9DB6, 16'h1D36, 16'hE0C9, 16'h6049
  };

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic settle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pop_rd(output logic [7:0] d);
    @(negedge clk); rd_pop_i = 1'b1;
    @(negedge clk); rd_pop_i = 1'b0; d = rd_data_o;
  endtask

  task automatic peek_rd(output logic [7:0] d);
    @(negedge clk); rd_peek_i = 1'b1;
    @(negedge clk); rd_peek_i = 1'b0; d = rd_data_o;
  endtask

  task automatic cfg_wr(logic a, logic [7:0] v);
    @(negedge clk); cfg_we_i = 1'b1; cfg_addr_i = a; cfg_wdata_i = v;
    @(negedge clk); cfg_we_i = 1'b0;
  endtask

  // gap between scan starts around a change made during the first scan
  task automatic meas_gap(output int g);
    int t1;
    do @(negedge clk); while (col_o != 8'hFE);
    t1 = cyc;
    keys[0][3] = 1'b1;
    do @(negedge clk); while (col_o != 8'hFE);
    g = cyc - t1;
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got 0x0 expected 0x1");
      finish_run();
    end
  end

  initial begin
    logic [7:0] d;
    int g, s0, k0, f0, bad_cols;
    settle(3);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R13 col_o", col_o, 8'hFF);
    chk("R13 rd_data_o", rd_data_o, 8'h00);
    chk("R13 pulses", {evt_stb_o, key_ovr_o, fifo_ovr_o}, 0);
    pop_rd(d); chk("R7 empty read", d, 8'h00);

    // R2 R3: default debounce 3 -> gap 10 + 3*3
    meas_gap(g); chk("R3 default debounce gap", g, 19);
    settle(80); pop_rd(d); chk("R4 press 0x84", d, 8'h84);
    keys[0][3] = 1'b0; settle(80); pop_rd(d); chk("R4 release 0x04", d, 8'h04);
    cfg_wr(1'b0, 8'd0); settle(20);
    meas_gap(g); chk("R3 zero acts as one", g, 13);
    settle(80); pop_rd(d); keys[0][3] = 1'b0; settle(80); pop_rd(d);
    cfg_wr(1'b0, 8'd5); settle(20);
    meas_gap(g); chk("R2 debounce 5 gap", g, 25);
    settle(100); pop_rd(d); keys[0][3] = 1'b0; settle(100); pop_rd(d);
    cfg_wr(1'b0, 8'd1); settle(20);

    // R4: table of single-key events
    s0 = stb_cnt;
    for (int i = 0; i < 8; i++) begin
      if (VEC[i][14]) sf[VEC[i][13:11]] = VEC[i][15];
      else keys[VEC[i][13:11]][VEC[i][10:8]] = VEC[i][15];
      settle(80);
      pop_rd(d); chk("R4 event code", d, VEC[i][7:0]);
      pop_rd(d); chk("R7 drained", d, 8'h00);
    end
    chk("R11 strobe count", stb_cnt - s0, 8);

    // R6 R8: two keys together, ordering and repeat read
    keys[5][0] = 1'b1; keys[1][2] = 1'b1; settle(80);
    peek_rd(d); chk("R8 peek head", d, 8'h93);
    peek_rd(d); chk("R8 peek again", d, 8'h93);
    pop_rd(d);  chk("R6 first by row", d, 8'h93);
    pop_rd(d);  chk("R6 second", d, 8'hD1);
    pop_rd(d);  chk("R7 empty after", d, 8'h00);
    keys[5][0] = 1'b0; keys[1][2] = 1'b0; settle(80);
    pop_rd(d); pop_rd(d);

    // R9: three keys
    k0 = kovr_cnt;
    keys[0][1] = 1'b1; keys[3][3] = 1'b1; keys[6][6] = 1'b1; settle(80);
    chk("R9 key overrun pulse", kovr_cnt - k0, 1);
    pop_rd(d); chk("R9 events kept", d, 8'h82);
    pop_rd(d); pop_rd(d); chk("R9 third event", d, 8'hE7);
    keys[0][1] = 1'b0; keys[3][3] = 1'b0; keys[6][6] = 1'b0; settle(80);
    chk("R9 no pulse on release", kovr_cnt - k0, 1);
    pop_rd(d); pop_rd(d); pop_rd(d);

    // R5: special key masks its row
    sf[2] = 1'b1; settle(80);
    pop_rd(d); chk("R5 special press", d, 8'hA9);
    keys[2][4] = 1'b1; settle(80);
    pop_rd(d); chk("R5 masked key silent", d, 8'h00);
    sf[2] = 1'b0; settle(80);
    pop_rd(d); chk("R6 column before special", d, 8'hA5);
    pop_rd(d); chk("R5 special release", d, 8'h29);
    keys[2][4] = 1'b0; settle(80);
    pop_rd(d); chk("R5 key release", d, 8'h25);

    // R10 R11: sixteen events into a 14-deep queue
    s0 = stb_cnt; f0 = fovr_cnt;
    for (int i = 0; i < 16; i++) begin
      keys[0][0] = ~keys[0][0];
      settle(80);
    end
    chk("R11 queued strobes", stb_cnt - s0, 14);
    chk("R10 overrun pulses", fovr_cnt - f0, 2);
    for (int i = 0; i < 14; i++) begin
      pop_rd(d); chk("R10 stored kept", d, (i % 2 == 0) ? 8'h81 : 8'h01);
    end
    pop_rd(d); chk("R7 empty after drain", d, 8'h00);

    // R12: no ticks, no scans; request starts one
    tick_i = 1'b0; settle(20);
    bad_cols = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk); if (col_o != 8'hFF) bad_cols++;
    end
    chk("R12 idle without ticks", bad_cols, 0);
    @(negedge clk); cfg_we_i = 1'b1; cfg_addr_i = 1'b1;
    @(negedge clk); cfg_we_i = 1'b0;
    chk("R12 request drives column 0", col_o, 8'hFE);
    @(negedge clk); chk("R1 column 1 next", col_o, 8'hFD);
    tick_i = 1'b1; settle(40);

    done = 1;
    finish_run();
  end
endmodule